// File: doc/BRIEF.md
# USB 2.0 PHY connect/disconnect retune sequencer

This block retunes one USB 2.0 PHY port each time the attached device connects or disconnects. On an event it walks a fixed series of page selects, reads and writes and hands each one to an external register-access engine through a request/acknowledge handshake. It can adjust the squelch sensitivity bits and step the DC driving level. It always restores the disconnect-detect level to its default value. It then pulses the automatic sensitivity calibration enable low for one millisecond, and finally writes a disconnect-detect level trimmed by a fuse code and a signed compensation. Every adjusted field goes through a saturating add, so the result always lies between zero and the field mask.

Configuration flags select which parts of the sequence run and where the disconnect-detect field lives. Numeric settings (masks, step, fuse code, compensation, driving shadow) are sampled live and must stay stable while a sequence runs. The flags are captured when the event is accepted. The block raises `done` for one cycle when the sequence ends.

Top module: `usb2_retune_seq`

## Requirements
- R1: With `cfg_toggle_en` low, an accepted event raises `done` in the following cycle and issues no access request.
- R2: With `cfg_dbl_sens` low, the sequence selects page 0, reads register 0xE7 and writes it back with bits 6:4 cleared on connect or set on disconnect, all other bits kept.
- R3: With `cfg_drv_toggle_en` high, the sequence selects page 0 and writes register 0xE4. On connect it writes `shadow_drv` unchanged. On disconnect the bits under `cfg_drv_mask` become the masked shadow field plus the signed `cfg_drv_step`, clamped to 0..mask, and the other bits come from the shadow.
- R4: The disconnect-detect field is then written with the default value 6. With `cfg_dis_at_p0` high the field is bits 7:4 of page 0 register 0xE4, based on `shadow_drv`. Otherwise it is bits 3:0 of page 1 register 0xE2, based on a fresh read of that register.
- R5: Calibration pulse: select page 1, read 0xE0, write it with bit 2 cleared, then write it with bit 2 set exactly WAIT = (CLK_HZ/1000)*CAL_MS cycles after the first write is acknowledged.
- R6: The final write puts field + trim + `dis_comp` (signed) in the disconnect field, clamped to 0..15. Its base is the same as in R4.
- R7: With `cfg_fuse_v2` low, the 4-bit fuse code v gives trim = v*rate for v <= 7 and -((v & 7)*rate) otherwise.
- R8: With `cfg_fuse_v2` high, trim equals the raw fuse code. A nonzero trim replaces the current field (result = trim + comp). A zero trim leaves result = field + comp.
- R9: An event that arrives while a sequence is running is ignored. `done` is high for exactly one cycle per accepted event.
- R10: A request holds `acc_req`, `acc_op`, `acc_addr` and `acc_wdata` steady until the cycle `acc_ack` is high. The op codes are 0 = page select (page number in `acc_wdata`, address 0), 1 = read and 2 = write. Read data is taken from `acc_rdata` in the acknowledge cycle.
- R11: The steps run in this order: sensitivity, driving, restore, calibration pulse, update, done. Steps that are disabled are skipped, and nothing is issued after the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Connect/disconnect event strobe |
| evt_connect | input | 1 | 1 = connect, 0 = disconnect |
| cfg_toggle_en | input | 1 | Enables the retune sequence |
| cfg_drv_toggle_en | input | 1 | Enables the driving-level step |
| cfg_dbl_sens | input | 1 | Double-sensitivity mode, skips the sensitivity step |
| cfg_dis_at_p0 | input | 1 | Disconnect field at page 0 0xE4[7:4] (1) or page 1 0xE2[3:0] (0) |
| cfg_fuse_v2 | input | 1 | Selects the version-2 fuse rule |
| cfg_fuse_rate | input | 2 | Version-1 trim multiplier |
| fuse_dis_code | input | 4 | Fuse disconnect trim code |
| dis_comp | input | 8 | Signed disconnect compensation |
| cfg_drv_mask | input | 8 | Driving field mask (0x0F or 0x1F) |
| cfg_drv_step | input | 8 | Signed driving step applied on disconnect |
| shadow_drv | input | 8 | Shadow copy of page 0 register 0xE4 |
| acc_req | output | 1 | Access request valid |
| acc_op | output | 2 | Access type |
| acc_addr | output | 8 | Register address |
| acc_wdata | output | 8 | Write data or page number |
| acc_ack | input | 1 | Access accepted/completed |
| acc_rdata | input | 8 | Read data, valid with acc_ack |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with CLK_HZ = 24000 and CAL_MS = 1, so the calibration wait is 24 cycles. This lets every event finish in well under a hundred cycles while the exact wait length stays measurable. With the default clock the wait would be 50000 cycles per event. The short build reaches both disconnect-field locations, both fuse rules, clamping at both ends and the busy-ignore window, all within one short run.

// File: rtl/retune_pkg.sv
package retune_pkg;

  typedef enum logic [1:0] {
    OP_PAGE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } acc_op_e;

  localparam int DATA_W = 8;
  localparam int SUM_W  = 12;

  localparam logic [DATA_W-1:0] REG_SENS   = 8'hE7;
  localparam logic [DATA_W-1:0] REG_DRV    = 8'hE4;
  localparam logic [DATA_W-1:0] REG_DIS_P1 = 8'hE2;
  localparam logic [DATA_W-1:0] REG_CAL    = 8'hE0;
  localparam logic [DATA_W-1:0] SENS_BITS  = 8'h70;
  localparam logic [DATA_W-1:0] CAL_BIT    = 8'h04;
  localparam logic [3:0]        DIS_DEFAULT = 4'd6;
  localparam logic [3:0]        DIS_MASK    = 4'hF;

  // saturating clamp of a signed sum into 0..mask
  function automatic logic [DATA_W-1:0] sat_field(input logic signed [SUM_W-1:0] sum,
                                                  input logic [DATA_W-1:0] mask);
    logic signed [SUM_W-1:0] lim;
    lim = $signed({4'b0000, mask});
    if (sum < 12'sd0) return '0;
    if (sum > lim) return mask;
    return sum[DATA_W-1:0];
  endfunction

  // fuse code to signed trim
  function automatic logic signed [DATA_W-1:0] fuse_trim(input logic [3:0] code,
                                                         input logic [1:0] rate,
                                                         input logic v2);
    logic [DATA_W-1:0] mag;
    mag = {5'b0, code[2:0]} * {6'b0, rate};
    if (v2) return $signed({4'b0000, code});
    if (code[3]) return -$signed(mag);
    return $signed(mag);
  endfunction

endpackage

// File: rtl/retune_delay.sv
module retune_delay #(
  parameter int WAIT_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= CW'(WAIT_CYCLES - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expire = active && (cnt == '0);

  // the controller must not restart a wait that is still running
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active)
    else $error("delay restarted while running");

  if (WAIT_CYCLES > 1) begin : g_min_wait
    assert_start_not_expired_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !expire)
      else $error("calibration wait ended too early");
  end

endmodule

// File: rtl/retune_trim.sv
module retune_trim
  import retune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_connect,
  input  logic              lat_at_p0,
  input  logic              cfg_fuse_v2,
  input  logic [1:0]        cfg_fuse_rate,
  input  logic [3:0]        fuse_dis_code,
  input  logic [DATA_W-1:0] dis_comp,
  input  logic [DATA_W-1:0] cfg_drv_mask,
  input  logic [DATA_W-1:0] cfg_drv_step,
  input  logic [DATA_W-1:0] shadow_drv,
  input  logic [DATA_W-1:0] sens_rd,
  input  logic [DATA_W-1:0] dis_rd,
  input  logic [DATA_W-1:0] cal_rd,
  output logic [DATA_W-1:0] sens_wd,
  output logic [DATA_W-1:0] drv_wd,
  output logic [DATA_W-1:0] rst_wd,
  output logic [DATA_W-1:0] upd_wd,
  output logic [DATA_W-1:0] cal_lo_wd,
  output logic [DATA_W-1:0] cal_hi_wd
);

  // sensitivity bits: clear on connect, set on disconnect
  assign sens_wd = lat_connect ? (sens_rd & ~SENS_BITS) : (sens_rd | SENS_BITS);

  // driving step
  logic signed [SUM_W-1:0] drv_sum;
  logic [DATA_W-1:0]       drv_fld;
  assign drv_sum = $signed({4'b0000, shadow_drv & cfg_drv_mask})
                 + $signed({{4{cfg_drv_step[7]}}, cfg_drv_step});
  assign drv_fld = sat_field(drv_sum, cfg_drv_mask);
  assign drv_wd  = lat_connect ? shadow_drv
                               : ((shadow_drv & ~cfg_drv_mask) | drv_fld);

  // disconnect field: base register and current field
  logic [DATA_W-1:0] dis_base;
  logic [3:0]        dis_fld;
  assign dis_base = lat_at_p0 ? shadow_drv : dis_rd;
  assign dis_fld  = lat_at_p0 ? dis_base[7:4] : dis_base[3:0];
  assign rst_wd   = lat_at_p0 ? {DIS_DEFAULT, dis_base[3:0]}
                              : {dis_base[7:4], DIS_DEFAULT};

  // trimmed update
  logic signed [DATA_W-1:0] trim;
  logic                     keep_fld;
  logic signed [SUM_W-1:0]  upd_sum;
  logic [DATA_W-1:0]        upd_fld;
  assign trim     = fuse_trim(fuse_dis_code, cfg_fuse_rate, cfg_fuse_v2);
  assign keep_fld = !(cfg_fuse_v2 && (trim != 8'sd0));
  assign upd_sum  = $signed({8'b0, keep_fld ? dis_fld : 4'd0})
                  + $signed({{4{trim[7]}}, trim})
                  + $signed({{4{dis_comp[7]}}, dis_comp});
  assign upd_fld  = sat_field(upd_sum, {4'b0000, DIS_MASK});
  assign upd_wd   = lat_at_p0 ? {upd_fld[3:0], dis_base[3:0]}
                              : {dis_base[7:4], upd_fld[3:0]};

  // calibration enable pulse values
  assign cal_lo_wd = cal_rd & ~CAL_BIT;
  assign cal_hi_wd = cal_rd | CAL_BIT;

  assert_drv_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_fld <= cfg_drv_mask)
    else $error("driving field out of range");

endmodule

// File: rtl/retune_ctrl.sv
module retune_ctrl
  import retune_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic              evt_connect,
  input  logic              cfg_toggle_en,
  input  logic              cfg_drv_toggle_en,
  input  logic              cfg_dbl_sens,
  input  logic              cfg_dis_at_p0,
  input  logic              acc_ack,
  input  logic [DATA_W-1:0] acc_rdata,
  input  logic [DATA_W-1:0] sens_wd,
  input  logic [DATA_W-1:0] drv_wd,
  input  logic [DATA_W-1:0] rst_wd,
  input  logic [DATA_W-1:0] upd_wd,
  input  logic [DATA_W-1:0] cal_lo_wd,
  input  logic [DATA_W-1:0] cal_hi_wd,
  input  logic              dly_expire,
  output logic              dly_start,
  output logic              acc_req,
  output logic [1:0]        acc_op,
  output logic [DATA_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              done,
  output logic              lat_connect,
  output logic              lat_at_p0,
  output logic [DATA_W-1:0] sens_rd,
  output logic [DATA_W-1:0] dis_rd,
  output logic [DATA_W-1:0] cal_rd
);

  typedef enum logic [4:0] {
    S_IDLE, S_SENS_PG, S_SENS_RD, S_SENS_WR, S_DRV_PG, S_DRV_WR,
    S_RST_PG, S_RST_RD, S_RST_WR, S_CAL_PG, S_CAL_RD, S_CAL_LO,
    S_CAL_WAIT, S_CAL_HI, S_UPD_PG, S_UPD_WR, S_DONE
  } step_e;

  step_e state, state_nx;
  logic  lat_drv;
  logic  accept;

  assign accept = (state == S_IDLE) && evt_valid;
  assign acc_req = !(state inside {S_IDLE, S_CAL_WAIT, S_DONE});
  assign done    = (state == S_DONE);
  assign dly_start = (state == S_CAL_LO) && acc_ack;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:
        if (evt_valid) begin
          if (!cfg_toggle_en)          state_nx = S_DONE;
          else if (!cfg_dbl_sens)      state_nx = S_SENS_PG;
          else if (cfg_drv_toggle_en)  state_nx = S_DRV_PG;
          else                         state_nx = S_RST_PG;
        end
      S_SENS_PG:  if (acc_ack) state_nx = S_SENS_RD;
      S_SENS_RD:  if (acc_ack) state_nx = S_SENS_WR;
      S_SENS_WR:  if (acc_ack) state_nx = lat_drv ? S_DRV_PG : S_RST_PG;
      S_DRV_PG:   if (acc_ack) state_nx = S_DRV_WR;
      S_DRV_WR:   if (acc_ack) state_nx = S_RST_PG;
      S_RST_PG:   if (acc_ack) state_nx = lat_at_p0 ? S_RST_WR : S_RST_RD;
      S_RST_RD:   if (acc_ack) state_nx = S_RST_WR;
      S_RST_WR:   if (acc_ack) state_nx = S_CAL_PG;
      S_CAL_PG:   if (acc_ack) state_nx = S_CAL_RD;
      S_CAL_RD:   if (acc_ack) state_nx = S_CAL_LO;
      S_CAL_LO:   if (acc_ack) state_nx = S_CAL_WAIT;
      S_CAL_WAIT: if (dly_expire) state_nx = S_CAL_HI;
      S_CAL_HI:   if (acc_ack) state_nx = S_UPD_PG;
      S_UPD_PG:   if (acc_ack) state_nx = S_UPD_WR;
      S_UPD_WR:   if (acc_ack) state_nx = S_DONE;
      S_DONE:     state_nx = S_IDLE;
      default:    state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      lat_connect <= 1'b0;
      lat_drv     <= 1'b0;
      lat_at_p0   <= 1'b0;
      sens_rd     <= '0;
      dis_rd      <= '0;
      cal_rd      <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        lat_connect <= evt_connect;
        lat_drv     <= cfg_drv_toggle_en;
        lat_at_p0   <= cfg_dis_at_p0;
      end
      if (acc_ack && state == S_SENS_RD) sens_rd <= acc_rdata;
      if (acc_ack && state == S_RST_RD)  dis_rd  <= acc_rdata;
      if (acc_ack && state == S_CAL_RD)  cal_rd  <= acc_rdata;
    end
  end

  // request fields per step
  always_comb begin
    acc_op    = OP_PAGE;
    acc_addr  = '0;
    acc_wdata = '0;
    unique case (state)
      S_SENS_PG, S_DRV_PG: acc_wdata = 8'd0;
      S_RST_PG, S_UPD_PG:  acc_wdata = lat_at_p0 ? 8'd0 : 8'd1;
      S_CAL_PG:            acc_wdata = 8'd1;
      S_SENS_RD: begin acc_op = OP_READ;  acc_addr = REG_SENS; end
      S_SENS_WR: begin acc_op = OP_WRITE; acc_addr = REG_SENS; acc_wdata = sens_wd; end
      S_DRV_WR:  begin acc_op = OP_WRITE; acc_addr = REG_DRV;  acc_wdata = drv_wd; end
      S_RST_RD:  begin acc_op = OP_READ;  acc_addr = REG_DIS_P1; end
      S_RST_WR:  begin
        acc_op = OP_WRITE; acc_addr = lat_at_p0 ? REG_DRV : REG_DIS_P1; acc_wdata = rst_wd;
      end
      S_CAL_RD:  begin acc_op = OP_READ;  acc_addr = REG_CAL; end
      S_CAL_LO:  begin acc_op = OP_WRITE; acc_addr = REG_CAL; acc_wdata = cal_lo_wd; end
      S_CAL_HI:  begin acc_op = OP_WRITE; acc_addr = REG_CAL; acc_wdata = cal_hi_wd; end
      S_UPD_WR:  begin
        acc_op = OP_WRITE; acc_addr = lat_at_p0 ? REG_DRV : REG_DIS_P1; acc_wdata = upd_wd;
      end
      default: ;
    endcase
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_op) && $stable(acc_addr) && $stable(acc_wdata))
    else $error("request changed before acknowledge");

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && evt_valid && !cfg_toggle_en |=> done && !acc_req)
    else $error("disabled retune issued traffic");

endmodule

// File: rtl/usb2_retune_seq.sv
module usb2_retune_seq
  import retune_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int CAL_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  logic       evt_connect,
  input  logic       cfg_toggle_en,
  input  logic       cfg_drv_toggle_en,
  input  logic       cfg_dbl_sens,
  input  logic       cfg_dis_at_p0,
  input  logic       cfg_fuse_v2,
  input  logic [1:0] cfg_fuse_rate,
  input  logic [3:0] fuse_dis_code,
  input  logic [7:0] dis_comp,
  input  logic [7:0] cfg_drv_mask,
  input  logic [7:0] cfg_drv_step,
  input  logic [7:0] shadow_drv,
  output logic       acc_req,
  output logic [1:0] acc_op,
  output logic [7:0] acc_addr,
  output logic [7:0] acc_wdata,
  input  logic       acc_ack,
  input  logic [7:0] acc_rdata,
  output logic       done
);
  localparam int WAIT_CYCLES = (CLK_HZ / 1000) * CAL_MS;

  logic              dly_start, dly_expire;
  logic              lat_connect, lat_at_p0;
  logic [DATA_W-1:0] sens_rd, dis_rd, cal_rd;
  logic [DATA_W-1:0] sens_wd, drv_wd, rst_wd, upd_wd, cal_lo_wd, cal_hi_wd;

  retune_ctrl u_ctrl (
    .clk, .rst_n, .evt_valid, .evt_connect, .cfg_toggle_en, .cfg_drv_toggle_en,
    .cfg_dbl_sens, .cfg_dis_at_p0, .acc_ack, .acc_rdata,
    .sens_wd, .drv_wd, .rst_wd, .upd_wd, .cal_lo_wd, .cal_hi_wd,
    .dly_expire, .dly_start, .acc_req, .acc_op, .acc_addr, .acc_wdata, .done,
    .lat_connect, .lat_at_p0, .sens_rd, .dis_rd, .cal_rd
  );

  retune_trim u_trim (
    .clk, .rst_n, .lat_connect, .lat_at_p0, .cfg_fuse_v2, .cfg_fuse_rate,
    .fuse_dis_code, .dis_comp, .cfg_drv_mask, .cfg_drv_step, .shadow_drv,
    .sens_rd, .dis_rd, .cal_rd,
    .sens_wd, .drv_wd, .rst_wd, .upd_wd, .cal_lo_wd, .cal_hi_wd
  );

  retune_delay #(.WAIT_CYCLES(WAIT_CYCLES)) u_delay (
    .clk, .rst_n, .start(dly_start), .expire(dly_expire)
  );

endmodule

// File: tb/usb2_retune_seq_tb.sv
module usb2_retune_seq_tb;

  localparam int TB_CLK_HZ = 24000;
  localparam int TB_WAIT   = 24;  // (24000/1000)*1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       evt_valid = 0, evt_connect = 0;
  logic       cfg_toggle_en = 0, cfg_drv_toggle_en = 0, cfg_dbl_sens = 0, cfg_dis_at_p0 = 0;
  logic       cfg_fuse_v2 = 0;
  logic [1:0] cfg_fuse_rate = 0;
  logic [3:0] fuse_dis_code = 0;
  logic [7:0] dis_comp = 0, cfg_drv_mask = 8'h0F, cfg_drv_step = 0, shadow_drv = 0;
  logic       acc_req, acc_ack = 0, done;
  logic [1:0] acc_op;
  logic [7:0] acc_addr, acc_wdata, acc_rdata = 0;

  usb2_retune_seq #(.CLK_HZ(TB_CLK_HZ), .CAL_MS(1)) u_dut (.*);

  int tests = 0, fails = 0, cyc = 0, done_cnt = 0, lo_cyc = 0;
  bit finished = 0;
  logic [7:0] mem [0:2][0:255];
  int cur_page = 0;

  typedef struct { int op; int addr; int data; bit chk; string tag; } exp_t;
  exp_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic int clampi(input int v, input int m);
    if (v < 0) return 0;
    if (v > m) return m;
    return v;
  endfunction

  function automatic int trim_of(input int code, input int rate, input bit v2);
    if (v2) return code;
    if (code <= 7) return code * rate;
    return -((code & 7) * rate);
  endfunction

  task automatic push(input int op, input int addr, input int data, input bit chk, input string tag);
    exp_t e;
    e.op = op; e.addr = addr; e.data = data; e.chk = chk; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // responder + scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
      end
      if (!rst_n) acc_ack = 0;
      else if (acc_ack) acc_ack = 0;
      else if (acc_req) begin
        if (exp_q.size() == 0) begin
          check(0, "R11 unexpected request", acc_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(acc_op) == e.op, {e.tag, " op"}, acc_op, e.op);
          check(int'(acc_addr) == e.addr, {e.tag, " addr"}, acc_addr, e.addr);
          if (e.chk) check(int'(acc_wdata) == e.data, {e.tag, " data"}, acc_wdata, e.data);
        end
        if (acc_op == 2'd2 && acc_addr == 8'hE0) begin
          if (!acc_wdata[2]) lo_cyc = cyc;
          else check(cyc - lo_cyc == TB_WAIT + 1, "R5 calibration wait", cyc - lo_cyc, TB_WAIT + 1);
        end
        case (acc_op)
          2'd0: cur_page = int'(acc_wdata);
          2'd1: acc_rdata = mem[cur_page][acc_addr];
          2'd2: mem[cur_page][acc_addr] = acc_wdata;
          default: ;
        endcase
        acc_ack = 1;
      end
    end
  end

  // driver: builds expectations from the requirements, then fires the event
  task automatic run_evt(input bit c, input string utag, input int again_at);
    int d0, n, base, p, fld, t, s, f, a;
    d0 = done_cnt;
    if (cfg_toggle_en) begin
      if (!cfg_dbl_sens) begin
        push(0, 0, 0, 1, "R10 page");
        push(1, 8'hE7, 0, 0, "R2 read");
        push(2, 8'hE7, c ? (mem[0][8'hE7] & 8'h8F) : (mem[0][8'hE7] | 8'h70), 1, "R2 write");
      end
      if (cfg_drv_toggle_en) begin
        push(0, 0, 0, 1, "R10 page");
        push(2, 8'hE4, c ? int'(shadow_drv)
             : ((int'(shadow_drv) & ~int'(cfg_drv_mask) & 8'hFF)
                | clampi((int'(shadow_drv) & int'(cfg_drv_mask)) + int'($signed(cfg_drv_step)),
                         int'(cfg_drv_mask))), 1, "R3 write");
      end
      p = cfg_dis_at_p0 ? 0 : 1;
      a = cfg_dis_at_p0 ? 8'hE4 : 8'hE2;
      base = cfg_dis_at_p0 ? int'(shadow_drv) : int'(mem[1][8'hE2]);
      push(0, 0, p, 1, "R10 page");
      if (!cfg_dis_at_p0) push(1, 8'hE2, 0, 0, "R4 read");
      push(2, a, cfg_dis_at_p0 ? ((base & 8'h0F) | 8'h60) : ((base & 8'hF0) | 6), 1, "R4 restore");
      push(0, 0, 1, 1, "R10 page");
      push(1, 8'hE0, 0, 0, "R5 read");
      push(2, 8'hE0, mem[1][8'hE0] & 8'hFB, 1, "R5 low");
      push(2, 8'hE0, mem[1][8'hE0] | 8'h04, 1, "R5 high");
      fld = cfg_dis_at_p0 ? (base >> 4) : (base & 15);
      t = trim_of(int'(fuse_dis_code), int'(cfg_fuse_rate), cfg_fuse_v2);
      s = (cfg_fuse_v2 && t != 0) ? t + int'($signed(dis_comp)) : fld + t + int'($signed(dis_comp));
      f = clampi(s, 15);
      push(0, 0, p, 1, "R10 page");
      push(2, a, cfg_dis_at_p0 ? ((base & 8'h0F) | (f << 4)) : ((base & 8'hF0) | f), 1, utag);
    end
    @(negedge clk); evt_valid = 1; evt_connect = c;
    @(negedge clk); evt_valid = 0;
    if (!cfg_toggle_en) check(done == 1'b1, "R1 done next cycle", done, 1);
    n = 0;
    while (done_cnt == d0 && !done && n < 3000) begin
      @(negedge clk); n++;
      if (n == again_at) begin
        evt_valid = 1; evt_connect = !c;
        @(negedge clk); evt_valid = 0; n++;
      end
    end
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R11 sequence complete", exp_q.size(), 0);
    check(done_cnt == d0 + 1, "R9 one done per event", done_cnt - d0, 1);
    exp_q.delete();
  endtask

  task automatic cfg(input bit tog, input bit drv, input bit dbl, input bit p0, input bit v2,
                     input int rate, input int code, input int comp, input int mask,
                     input int step, input int shd);
    @(negedge clk);
    cfg_toggle_en = tog; cfg_drv_toggle_en = drv; cfg_dbl_sens = dbl; cfg_dis_at_p0 = p0;
    cfg_fuse_v2 = v2; cfg_fuse_rate = 2'(rate); fuse_dis_code = 4'(code);
    dis_comp = 8'(comp); cfg_drv_mask = 8'(mask); cfg_drv_step = 8'(step); shadow_drv = 8'(shd);
  endtask

  initial begin
    for (int pg = 0; pg < 3; pg++)
      for (int r = 0; r < 256; r++) mem[pg][r] = 8'h00;
    mem[0][8'hE7] = 8'h05;
    mem[1][8'hE0] = 8'h3E;
    mem[1][8'hE2] = 8'h53;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(acc_req == 1'b0, "R10 reset request low", acc_req, 0);
    check(done == 1'b0, "R9 reset done low", done, 0);

    // R2/R4/R5/R6: disconnect then connect, field at page 0, v1 code 3
    cfg(1, 0, 0, 1, 0, 1, 3, 0, 8'h0F, 0, 8'h48);
    run_evt(0, "R6 update p0", 0);
    run_evt(1, "R6 update p0", 0);
    // R3: driving step with clamp at mask 0x1F
    cfg(1, 1, 1, 1, 0, 1, 3, 0, 8'h1F, 8, 8'hB9);
    run_evt(0, "R6 update drv", 0);
    run_evt(1, "R6 update drv", 0);
    // R7: negative v1 trim, page 1 field, clamp at 0
    cfg(1, 0, 1, 0, 0, 2, 4'hA, -8, 8'h0F, 0, 8'h00);
    run_evt(0, "R7 negative trim", 0);
    // R8: v2 nonzero trim replaces field, then zero trim keeps field
    cfg(1, 0, 1, 0, 1, 1, 9, -2, 8'h0F, 0, 8'h00);
    run_evt(1, "R8 trim replaces", 0);
    cfg(1, 0, 1, 0, 1, 1, 0, 2, 8'h0F, 0, 8'h00);
    run_evt(0, "R8 zero trim", 0);
    // R6: upper clamp
    cfg(1, 0, 1, 0, 0, 1, 5, 100, 8'h0F, 0, 8'h00);
    run_evt(0, "R6 upper clamp", 0);
    // R9: second event mid-sequence is ignored
    cfg(1, 0, 0, 1, 0, 1, 3, 0, 8'h0F, 0, 8'h48);
    run_evt(0, "R9 busy update", 10);
    // R1: toggle disabled
    cfg(0, 1, 0, 1, 0, 1, 3, 0, 8'h0F, 0, 8'h48);
    run_evt(0, "R1 none", 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule